// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

This block is a six-pin general-purpose I/O port that sits behind a simple register bus. Each pin has a stored data bit and a direction bit. When a pin is set as an output, its data bit drives the pin. When a pin is set as an input, a read of its data bit returns the pin level after a two-flop synchronizer. A read of an output pin returns the stored value instead.

Two serial peripherals can take pins away from the GPIO registers. An enabled SPI unit owns the upper four pins: clock on bit 5, MOSI on bit 4, slave select on bit 3 and MISO on bit 2. It drives their output values and enables from its own per-pin signals. An enabled CAN controller owns the lowest two pins: transmit on bit 1 and receive on bit 0. Synchronized pin levels are always fed back to both peripherals. A reserved register sits one address below the data register. It reads zero and ignores writes.

Register offsets, all parameters: 0 is the reserved register, 1 is the data register, 3 is the direction register. Every other offset reads 0. Writes take effect on the rising clock edge when `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the data and direction registers hold 0, every `pin_oe` bit is 0, and a read of offset 1 returns 0 while the pins are low.
- R2: A write to offset 1 stores `bus_wdata[5:0]` in the data register. Bits 7 and 6 of a read at offset 1 are always 0.
- R3: For each bit i of a read at offset 1, the value is the stored data bit when direction bit i is 1. When direction bit i is 0, the value is the pin input as it was two rising edges earlier.
- R4: With no peripheral override on a pin, `pin_oe[i]` equals direction bit i and `pin_out[i]` equals data bit i.
- R5: While `spi_en` is 1, `pin_oe[5:2]` equals `spi_oe[3:0]` and `pin_out[5:2]` equals `spi_do[3:0]`. Data register writes made in this time are still stored, and they reach `pin_out[5:2]` once `spi_en` falls.
- R6: While `can_en` is 1, `pin_oe[1]` is 1, `pin_out[1]` equals `can_tx`, and `pin_oe[0]` is 0, whatever the direction register holds.
- R7: A read at offset 0 returns 0x00. A write to offset 0 changes neither the data register nor the direction register.
- R8: `spi_di[3:0]` equals `pin_in[5:2]`, and `can_rx` equals `pin_in[0]`, as the pins were two rising edges earlier.
- R9: A write to offset 3 stores `bus_wdata[5:0]` as the direction register, where 1 means output. A read at offset 3 returns it, with bits 7 and 6 reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 6 | Raw pin input levels |
| pin_out | output | 6 | Pin output values |
| pin_oe | output | 6 | Pin output enables |
| spi_en | input | 1 | SPI owns pins 5 to 2 |
| spi_do | input | 4 | SPI output values for pins 5 to 2 |
| spi_oe | input | 4 | SPI output enables for pins 5 to 2 |
| spi_di | output | 4 | Synchronized pins 5 to 2 to the SPI |
| can_en | input | 1 | CAN owns pins 1 and 0 |
| can_tx | input | 1 | CAN transmit level for pin 1 |
| can_rx | output | 1 | Synchronized pin 0 to the CAN |

## Verification
The assertions check on every cycle that SPI and CAN precedence holds on the output pins. They also check that the reserved offset and the unused upper data bits read zero, and that the peripheral inputs follow the pins with a two-edge delay. Other behaviour can only be shown by the bench's scenarios. This covers the choice of read source by direction bit, the exact latency seen on a bus read, writes being kept while the SPI owns the pins and appearing after it releases them, and reserved-register writes leaving both registers untouched.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
   localparam int BUS_DW = 8;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_RSV,
      SEL_DATA,
      SEL_DIR
   } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("gpio_ovr_sync: STAGES must be non-negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st <= '0;
         end else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
   import gpio_ovr_pkg::*;
#(
   parameter int NPIN     = 6,
   parameter int AW       = 4,
   parameter int RSV_OFS  = 0,
   parameter int DATA_OFS = 1,
   parameter int DIR_OFS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic [NPIN-1:0]   pin_sync,
   output logic [NPIN-1:0]   data_q,
   output logic [NPIN-1:0]   dir_q
);
   reg_sel_e        sel;
   logic [NPIN-1:0] rd_view;

   always_comb begin
      if (bus_addr == AW'(DATA_OFS))      sel = SEL_DATA;
      else if (bus_addr == AW'(DIR_OFS))  sel = SEL_DIR;
      else if (bus_addr == AW'(RSV_OFS))  sel = SEL_RSV;
      else                                sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else if (bus_wr) begin
         if (sel == SEL_DATA) data_q <= bus_wdata[NPIN-1:0];
         if (sel == SEL_DIR)  dir_q  <= bus_wdata[NPIN-1:0];
      end
   end

   assign rd_view = (dir_q & data_q) | (~dir_q & pin_sync);

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_DATA: bus_rdata[NPIN-1:0] = rd_view;
         SEL_DIR:  bus_rdata[NPIN-1:0] = dir_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_ovr_mux.sv
module gpio_ovr_mux #(
   parameter int NPIN       = 6,
   parameter int SPI_LO     = 2,
   parameter int SPI_N      = 4,
   parameter int CAN_TX_BIT = 1,
   parameter int CAN_RX_BIT = 0
) (
   input  logic [NPIN-1:0]  data_q,
   input  logic [NPIN-1:0]  dir_q,
   input  logic             spi_en,
   input  logic [SPI_N-1:0] spi_do,
   input  logic [SPI_N-1:0] spi_oe,
   input  logic             can_en,
   input  logic             can_tx,
   output logic [NPIN-1:0]  pin_out,
   output logic [NPIN-1:0]  pin_oe
);
   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      if (i >= SPI_LO && i < SPI_LO + SPI_N) begin : g_spi
         localparam int K = i - SPI_LO;
         assign pin_out[i] = spi_en ? spi_do[K] : data_q[i];
         assign pin_oe[i]  = spi_en ? spi_oe[K] : dir_q[i];
      end else if (i == CAN_TX_BIT) begin : g_tx
         assign pin_out[i] = can_en ? can_tx : data_q[i];
         assign pin_oe[i]  = can_en | dir_q[i];
      end else if (i == CAN_RX_BIT) begin : g_rx
         assign pin_out[i] = data_q[i];
         assign pin_oe[i]  = ~can_en & dir_q[i];
      end else begin : g_plain
         assign pin_out[i] = data_q[i];
         assign pin_oe[i]  = dir_q[i];
      end
   end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
   import gpio_ovr_pkg::*;
#(
   parameter int NPIN        = 6,
   parameter int AW          = 4,
   parameter int RSV_OFS     = 0,
   parameter int DATA_OFS    = 1,
   parameter int DIR_OFS     = 3,
   parameter int SPI_LO      = 2,
   parameter int SPI_N       = 4,
   parameter int CAN_TX_BIT  = 1,
   parameter int CAN_RX_BIT  = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   input  logic              spi_en,
   input  logic [SPI_N-1:0]  spi_do,
   input  logic [SPI_N-1:0]  spi_oe,
   output logic [SPI_N-1:0]  spi_di,
   input  logic              can_en,
   input  logic              can_tx,
   output logic              can_rx
);
   if (NPIN > BUS_DW) begin : g_bad_npin
      $error("gpio_ovr_port: NPIN exceeds bus width");
   end
   if (SPI_LO + SPI_N > NPIN) begin : g_bad_spi
      $error("gpio_ovr_port: SPI pins fall outside the port");
   end
   if (CAN_TX_BIT == CAN_RX_BIT || CAN_TX_BIT >= NPIN || CAN_RX_BIT >= NPIN) begin : g_bad_can
      $error("gpio_ovr_port: CAN pin positions invalid");
   end
   if (RSV_OFS == DATA_OFS || DIR_OFS == DATA_OFS || DIR_OFS == RSV_OFS) begin : g_bad_ofs
      $error("gpio_ovr_port: register offsets collide");
   end

   logic [NPIN-1:0] pin_sync;
   logic [NPIN-1:0] data_q;
   logic [NPIN-1:0] dir_q;

   gpio_ovr_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   gpio_ovr_regs #(
      .NPIN(NPIN), .AW(AW), .RSV_OFS(RSV_OFS), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
      .data_q(data_q), .dir_q(dir_q)
   );

   gpio_ovr_mux #(
      .NPIN(NPIN), .SPI_LO(SPI_LO), .SPI_N(SPI_N),
      .CAN_TX_BIT(CAN_TX_BIT), .CAN_RX_BIT(CAN_RX_BIT)
   ) mux_i (
      .data_q(data_q), .dir_q(dir_q), .spi_en(spi_en), .spi_do(spi_do),
      .spi_oe(spi_oe), .can_en(can_en), .can_tx(can_tx),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   assign spi_di = pin_sync[SPI_LO +: SPI_N];
   assign can_rx = pin_sync[CAN_RX_BIT];
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk
   import gpio_ovr_pkg::*;
#(
   parameter int NPIN       = 6,
   parameter int AW         = 4,
   parameter int RSV_OFS    = 0,
   parameter int DATA_OFS   = 1,
   parameter int SPI_LO     = 2,
   parameter int SPI_N      = 4,
   parameter int CAN_TX_BIT = 1,
   parameter int CAN_RX_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [AW-1:0]     bus_addr,
   input logic [BUS_DW-1:0] bus_rdata,
   input logic [NPIN-1:0]   pin_in,
   input logic [NPIN-1:0]   pin_out,
   input logic [NPIN-1:0]   pin_oe,
   input logic              spi_en,
   input logic [SPI_N-1:0]  spi_do,
   input logic [SPI_N-1:0]  spi_oe,
   input logic [SPI_N-1:0]  spi_di,
   input logic              can_en,
   input logic              can_tx,
   input logic              can_rx
);
   logic [1:0] edges;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           edges <= '0;
      else if (edges != 2'd3) edges <= edges + 2'd1;
   end
   wire armed = (edges == 2'd3);

   // R5
   spi_owns_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_en |-> (pin_oe[SPI_LO +: SPI_N] == spi_oe) && (pin_out[SPI_LO +: SPI_N] == spi_do));

   // R6
   can_owns_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      can_en |-> pin_oe[CAN_TX_BIT] && !pin_oe[CAN_RX_BIT] && (pin_out[CAN_TX_BIT] == can_tx));

   // R7
   rsv_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(RSV_OFS)) |-> (bus_rdata == '0));

   // R2
   data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(DATA_OFS)) |-> (bus_rdata[BUS_DW-1:NPIN] == '0));

   // R8
   can_rx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (can_rx == $past(pin_in[CAN_RX_BIT], 2)));

   // R8
   spi_di_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (spi_di == $past(pin_in[SPI_LO +: SPI_N], 2)));
endmodule

bind gpio_ovr_port gpio_ovr_chk #(
   .NPIN(NPIN), .AW(AW), .RSV_OFS(RSV_OFS), .DATA_OFS(DATA_OFS),
   .SPI_LO(SPI_LO), .SPI_N(SPI_N), .CAN_TX_BIT(CAN_TX_BIT), .CAN_RX_BIT(CAN_RX_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .spi_en(spi_en),
   .spi_do(spi_do), .spi_oe(spi_oe), .spi_di(spi_di), .can_en(can_en),
   .can_tx(can_tx), .can_rx(can_rx)
);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_RSV = 4'd0, A_DATA = 4'd1, A_DIR = 4'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [5:0] pin_in = '0;
   logic [5:0] pin_out, pin_oe;
   logic       spi_en = 1'b0;
   logic [3:0] spi_do = '0, spi_oe = '0, spi_di;
   logic       can_en = 1'b0, can_tx = 1'b0, can_rx;

   int checks = 0;
   int errors = 0;
   logic [5:0] m_data = '0, m_dir = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_ovr_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .spi_en(spi_en), .spi_do(spi_do),
      .spi_oe(spi_oe), .spi_di(spi_di), .can_en(can_en), .can_tx(can_tx),
      .can_rx(can_rx)
   );

   function automatic logic [7:0] exp_rd(logic [5:0] d, logic [5:0] r, logic [5:0] p);
      return {2'b00, (r & d) | (~r & p)};
   endfunction

   function automatic logic [5:0] exp_oe(logic [5:0] r, logic se, logic [3:0] so, logic ce);
      logic [5:0] v = r;
      if (se) v[5:2] = so;
      if (ce) begin v[1] = 1'b1; v[0] = 1'b0; end
      return v;
   endfunction

   function automatic logic [5:0] exp_out(logic [5:0] d, logic se, logic [3:0] sd, logic ce, logic tx);
      logic [5:0] v = d;
      if (se) v[5:2] = sd;
      if (ce) v[1] = tx;
      return v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == A_DATA) m_data = d[5:0];
      if (a == A_DIR)  m_dir  = d[5:0];
   endtask

   task automatic bus_read(logic [3:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(A_DATA, rd); chk("R1 data", rd, 8'h00);
      bus_read(A_DIR, rd);  chk("R1 dir", rd, 8'h00);
      chk("R1 oe", pin_oe, 6'h00);

      // R2 and R9: upper bits discarded
      bus_write(A_DIR, 8'hFF);
      bus_read(A_DIR, rd); chk("R9 dir readback", rd, 8'h3F);
      bus_write(A_DATA, 8'hE5);
      bus_read(A_DATA, rd); chk("R2 data readback", rd, 8'h25);
      chk("R4 out", pin_out, 6'h25);
      chk("R4 oe", pin_oe, 6'h3F);

      // R7 reserved: read zero, write no effect
      bus_write(A_RSV, 8'h00);
      bus_read(A_RSV, rd);  chk("R7 rsv read", rd, 8'h00);
      bus_read(A_DATA, rd); chk("R7 data kept", rd, 8'h25);
      bus_read(A_DIR, rd);  chk("R7 dir kept", rd, 8'h3F);
      bus_write(A_RSV, 8'hFF);
      bus_read(A_RSV, rd);  chk("R7 rsv read after write", rd, 8'h00);
      m_data = 6'h25; m_dir = 6'h3F;
      bus_read(A_DIR, rd);  chk("R7 dir kept 2", rd, 8'h3F);

      // R3 latency: inputs, pins change
      bus_write(A_DIR, 8'h00);
      pin_in = 6'h0F; settle();
      bus_addr = A_DATA;
      @(negedge clk); pin_in = 6'h30;
      @(negedge clk); #1 chk("R3 one edge old", bus_rdata, 8'h0F);
      @(negedge clk); #1 chk("R3 two edges new", bus_rdata, 8'h30);
      chk("R8 spi_di", spi_di, 4'hC);
      chk("R8 can_rx", can_rx, 1'b0);

      // R3 mixed direction
      bus_write(A_DIR, 8'h15);
      bus_read(A_DATA, rd); chk("R3 mixed", rd, exp_rd(6'h25, 6'h15, 6'h30));

      // R5 write under SPI, visible after release
      spi_en = 1'b1; spi_do = 4'h9; spi_oe = 4'h6;
      bus_write(A_DATA, 8'h3C);
      chk("R5 spi out", pin_out[5:2], 4'h9);
      chk("R5 spi oe", pin_oe[5:2], 4'h6);
      spi_en = 1'b0; #1;
      chk("R5 after release", pin_out, 6'h3C);

      // R6 CAN forces direction
      bus_write(A_DIR, 8'h01);
      can_en = 1'b1; can_tx = 1'b1; #1;
      chk("R6 oe", pin_oe[1:0], 2'b10);
      chk("R6 tx", pin_out[1], 1'b1);
      can_en = 1'b0; #1;
      chk("R6 released", pin_oe[1:0], 2'b01);

      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [7:0] w;
         w = 8'($urandom);
         case ($urandom % 3)
            0: bus_write(A_DATA, w);
            1: bus_write(A_DIR, w);
            default: bus_write(A_RSV, w);
         endcase
         spi_en = 1'($urandom); spi_do = 4'($urandom); spi_oe = 4'($urandom);
         can_en = 1'($urandom); can_tx = 1'($urandom);
         pin_in = 6'($urandom);
         settle();
         bus_read(A_DATA, rd);
         chk("R3 random read", rd, exp_rd(m_data, m_dir, pin_in));
         chk("R5/R6 random oe", pin_oe, exp_oe(m_dir, spi_en, spi_oe, can_en));
         chk("R4 random out", pin_out, exp_out(m_data, spi_en, spi_do, can_en, can_tx));
         chk("R8 random feed", {spi_di, can_rx}, {pin_in[5:2], pin_in[0]});
         bus_read(A_DIR, rd);  chk("R9 random dir", rd, {2'b00, m_dir});
         bus_read(A_RSV, rd);  chk("R7 random rsv", rd, 8'h00);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule